// File: doc/BRIEF.md
# Serial Configuration Port with Burst Readback

This block is the slave side of a four-wire serial control link that serves twelve 8-bit configuration registers, numbered 1 to 12. An external master lowers a select line, clocks a 16-bit frame in MSB-first order on a serial clock, and raises select to finish. The first header bit picks read or write. The next seven bits give a register index. The last eight bits carry write data, or they are the slot where read data is returned on the serial output.

Register 11 controls burst reads. When its enable bit is set and a read frame carries index 0, the port returns consecutive registers for as long as select stays low. The burst begins at the start index held in register 11 and wraps from register 12 back to register 1. The select, serial clock and serial input pins are brought into the fast system clock domain through two-stage synchronizers and then edge-detected. The output-enable is a port of its own, so that a pad or a bench can see when the serial output is in high impedance.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset all twelve registers read 0x00, `sdout_oe` is 0 and `sdout` is 0.
- R2: A write frame has bit 15 = 0, then index bits 14:8, then data bits 7:0, each captured on a rising `sclk` edge. It updates the indexed register when `sel_n` rises after exactly 16 rising edges.
- R3: A frame with R/W = 0 that ends after fewer or more than 16 rising `sclk` edges changes no register.
- R4: A write to an index outside 1..12 changes no register. A single read of such an index returns 0x00.
- R5: A read frame (bit 15 = 1) whose index is nonzero, or that arrives while the burst enable is 0, returns the indexed register MSB-first in each byte after the header. The same register repeats for every further byte.
- R6: `sdout_oe` stays 0 during the eight header clocks and whenever `sel_n` is high. In a read frame it goes to 1 after the falling `sclk` edge that follows the 8th rising edge. While `sdout_oe` is 0, `sdout` is 0.
- R7: `sdout` changes only after a falling `sclk` edge or a `sel_n` transition, so it is stable while `sclk` is high.
- R8: Register 11 holds the burst enable in bit 7 and the start index in bits 6:0. A read frame with index 0 while the enable is 1 returns the start register first and then the next register for each further byte.
- R9: During a burst the pointer goes from register 12, or from any index at or above 12, back to register 1. A start index of 0 returns 0x00 first and then register 1.
- R10: Serial input bits after the header of a read frame are ignored and change no register.
- R11: A falling `sel_n` always starts a new frame from bit 0. A frame cut short by a rising `sel_n` leaves nothing behind that affects the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdin | input | 1 | Serial data from the master, sampled on rising `sclk` |
| sdout | output | 1 | Serial read data, updated after falling `sclk` |
| sdout_oe | output | 1 | High while `sdout` is driven; low means high impedance |

## Verification
A corrupted bit counter shows up within one frame, either as a header clock where `sdout_oe` is high or as read data shifted by one position. A bad burst pointer shows up in the first byte that crosses the wrap point. Each expected byte is queued from a register model before its frame starts. The comparison is then made when the eighth bit of each byte has been sampled. A write that commits by mistake, whether from a truncated frame or from trailing read bits, is caught by the next readback of that register.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int NREG       = 12,
  parameter int DW         = 8,
  parameter int IW         = 7,
  parameter int BURST_ADDR = 11,
  parameter int SYNC       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic sdin,
  output logic sdout,
  output logic sdout_oe
);
  localparam int HW  = 1 + IW;
  localparam int FW  = HW + DW;
  localparam int CW  = $clog2(FW) + 2;
  localparam int OBW = $clog2(DW);

  logic [SYNC:0]   sel_p, clk_p, din_p;
  logic [FW-1:0]   shreg;
  logic [CW-1:0]   cnt;
  logic [NREG:1][DW-1:0] regs;
  logic [DW-1:0]   obyte;
  logic [OBW-1:0]  obit;
  logic [IW-1:0]   ptr;
  logic            burst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_p <= '1;
      clk_p <= '0;
      din_p <= '0;
    end else begin
      sel_p <= {sel_p[SYNC-1:0], sel_n};
      clk_p <= {clk_p[SYNC-1:0], sclk};
      din_p <= {din_p[SYNC-1:0], sdin};
    end

  wire sel_fall  = ~sel_p[SYNC-1] &  sel_p[SYNC];
  wire sel_rise  =  sel_p[SYNC-1] & ~sel_p[SYNC];
  wire act       = ~sel_p[SYNC-1] & ~sel_p[SYNC];
  wire sclk_rise =  clk_p[SYNC-1] & ~clk_p[SYNC];
  wire sclk_fall = ~clk_p[SYNC-1] &  clk_p[SYNC];
  wire din_s     =  din_p[SYNC-1];

  function automatic logic [DW-1:0] rd_val(input logic [IW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    for (int k = 1; k <= NREG; k++)
      if (a == IW'(k)) v = regs[k];
    return v;
  endfunction

  wire          burst_en  = regs[BURST_ADDR][DW-1];
  wire [IW-1:0] start_idx = regs[BURST_ADDR][IW-1:0];
  wire [IW-1:0] hdr_idx   = shreg[IW-1:0];
  wire          hdr_burst = burst_en && (hdr_idx == '0);
  wire [IW-1:0] first_ptr = hdr_burst ? start_idx : hdr_idx;
  wire [IW-1:0] wrap_ptr  = (ptr >= IW'(NREG)) ? IW'(1) : ptr + IW'(1);
  wire [IW-1:0] next_ptr  = burst ? wrap_ptr : ptr;
  wire          byte_done = sdout_oe && (obit == OBW'(DW - 1));
  wire          commit    = sel_rise && (cnt == CW'(FW)) && !shreg[FW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (sel_fall) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (act && sclk_rise) begin
      shreg <= {shreg[FW-2:0], din_s};
      if (cnt != '1) cnt <= cnt + CW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) regs <= '0;
    else if (commit)
      for (int k = 1; k <= NREG; k++)
        if (shreg[FW-2:DW] == IW'(k)) regs[k] <= shreg[DW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sdout_oe <= 1'b0;
      obyte    <= '0;
      obit     <= '0;
      ptr      <= '0;
      burst    <= 1'b0;
    end else if (sel_fall || sel_rise) begin
      sdout_oe <= 1'b0;
      obit     <= '0;
    end else if (act && sclk_fall) begin
      if (!sdout_oe) begin
        if (cnt == CW'(HW) && shreg[HW-1]) begin
          sdout_oe <= 1'b1;
          burst    <= hdr_burst;
          ptr      <= first_ptr;
          obyte    <= rd_val(first_ptr);
          obit     <= '0;
        end
      end else if (byte_done) begin
        ptr   <= next_ptr;
        obyte <= rd_val(next_ptr);
        obit  <= '0;
      end else begin
        obyte <= {obyte[DW-2:0], 1'b0};
        obit  <= obit + OBW'(1);
      end
    end

  assign sdout = sdout_oe & obyte[DW-1];

  p_regs_change_at_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_rise |=> $stable(regs));

  p_hiz_in_header_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act && cnt < CW'(HW)) |-> !sdout_oe);

  p_hiz_outside_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_p[SYNC] |-> !sdout_oe);

  p_sdout_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !sel_rise && !sel_fall) |=> $stable(sdout));

  p_ptr_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && sclk_fall && byte_done && burst && ptr == IW'(NREG)) |=> (ptr == IW'(1)));
endmodule

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_oe;

  serial_cfg_port u_dut (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk),
                         .sdin(sdin), .sdout(sdout), .sdout_oe(sdout_oe));

  int checks = 0, errors = 0;
  logic [7:0] m [0:15];
  logic [7:0] expq[$];
  string      tagq[$];
  logic [7:0] got_byte;
  event       got;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mv(input int i);
    return (i >= 1 && i <= 12) ? m[i] : 8'h00;
  endfunction

  initial forever begin
    @(got);
    if (expq.size() == 0) chk(0, "R5 unexpected byte", got_byte, 0);
    else begin
      logic [7:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(got_byte == e, t, got_byte, e);
    end
  end

  task automatic frame(input logic rw, input logic [6:0] idx, input logic [7:0] dat,
                       input int nbits);
    logic [15:0] w;
    logic [7:0] acc;
    logic b;
    bit hz_ok, drv_ok, stab_ok;
    w = {rw, idx, dat};
    acc = '0; hz_ok = 1; drv_ok = 1; stab_ok = 1;
    @(negedge clk) sel_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 16) ? w[15-i] : 1'b1;
      repeat (8) @(negedge clk);
      if (i < 8 && sdout_oe) hz_ok = 0;
      if (i >= 8 && rw && !sdout_oe) drv_ok = 0;
      acc = {acc[6:0], sdout};
      b = sdout;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      if (sdout !== b) stab_ok = 0;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      if (rw && i >= 8 && ((i - 8) % 8) == 7) begin
        got_byte = acc;
        ->got;
      end
    end
    repeat (8) @(negedge clk);
    sel_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(!sdout_oe && !sdout, "R6 idle after frame", sdout_oe, 0);
    if (rw) begin
      chk(hz_ok, "R6 header hi-z", hz_ok, 1);
      chk(drv_ok, "R6 data driven", drv_ok, 1);
      chk(stab_ok, "R7 stable while sclk high", stab_ok, 1);
    end
    if (!rw && nbits == 16 && idx >= 1 && idx <= 12) m[idx] = dat;
  endtask

  task automatic wr(input int idx, input logic [7:0] dat, input int nbits);
    frame(1'b0, 7'(idx), dat, nbits);
  endtask

  task automatic rd(input int idx, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      expq.push_back(mv(idx));
      tagq.push_back(tag);
    end
    frame(1'b1, 7'(idx), 8'hFF, 8 + 8 * n);
  endtask

  task automatic burst(input int n, input string tag);
    int p;
    p = int'(m[11][6:0]);
    for (int k = 0; k < n; k++) begin
      expq.push_back(mv(p));
      tagq.push_back(tag);
      p = (p >= 12) ? 1 : p + 1;
    end
    frame(1'b1, 7'd0, 8'hFF, 8 + 8 * n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!sdout_oe && !sdout, "R1 outputs after reset", {sdout_oe, sdout}, 0);
    rd(3, 1, "R1 reset value");
    rd(12, 1, "R1 reset value");

    wr(3, 8'hA5, 16);
    wr(2, 8'h5A, 16);
    wr(12, 8'h3C, 16);
    wr(1, 8'h81, 16);
    rd(3, 1, "R2 write then read");
    rd(2, 2, "R5 single read repeats");
    rd(12, 1, "R2 last register");

    frame(1'b0, 7'd3, 8'hFF, 15);
    rd(3, 1, "R3 short write ignored");
    frame(1'b0, 7'd3, 8'hFF, 17);
    rd(3, 1, "R3 long write ignored");

    wr(13, 8'h77, 16);
    rd(13, 1, "R4 out of range read");
    rd(0, 1, "R4 index zero without burst");

    rd(2, 2, "R10 trailing read bits");
    rd(2, 1, "R10 register unchanged");

    frame(1'b0, 7'd5, 8'h00, 5);
    wr(5, 8'hC3, 16);
    rd(5, 1, "R11 aborted frame then write");

    wr(11, 8'h80 | 8'd10, 16);
    burst(6, "R8 R9 burst with wrap");
    rd(3, 1, "R5 nonzero index with burst enabled");

    wr(11, 8'h80, 16);
    burst(4, "R9 start at zero");

    wr(11, 8'h0A, 16);
    rd(0, 1, "R8 burst disabled");

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R5 all bytes received", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule